// File: doc/BRIEF.md
# Host command stream decoder

This block turns a stream of 32-bit command words into register-write transactions and side-band event pulses. Words arrive one per cycle over a valid/ready handshake. The decoder treats each word as either a header or a payload word. A header picks an opcode, an addressing rule and a payload length. Each payload word that follows is turned into one write carrying the current 10-bit class, a 12-bit register offset and the 32-bit word as data.

Some headers produce an event instead of, or as well as, writes. These are restart, gather, lock acquire, lock release, done and decode error. Gather fetching, bus access and lock arbitration belong to the blocks that consume these pulses. Every output is registered, and each output reflects the word accepted on the previous clock edge.

Top module: `cmdstream_decoder`

## Requirements
- R1: After a synchronous active-low reset, the decoder expects a header, the current class is 0 and every pulse output is low. `in_ready` is always high, so every word presented with `in_valid` high is accepted.
- R2: A header's opcode is bits 31:28. Opcode 0x0 sets the class and has a 12-bit offset in bits 27:16 and a 6-bit mask in bits 5:0. It takes one payload word per set mask bit. Payload word k goes to offset + (index of the k-th set bit, counted from bit 0 upward). A zero mask takes no payload.
- R3: The current class is written only by an opcode 0x0 header, from its bits 15:6. Every later write, including the payload of that same header, carries that class on `wr_class`.
- R4: Opcode 0x1 has an offset in bits 25:16 and a count in bits 15:0. Its payload words go to offset, offset+1, offset+2 and so on. Offsets wrap modulo 4096.
- R5: Opcode 0x2 has the same fields as opcode 0x1, but every payload word goes to the same offset.
- R6: Opcode 0x3 has an offset in bits 25:16 and a 16-bit mask in bits 15:0. Its payload follows the set-bit rule of R2.
- R7: Opcode 0x4 writes bits 15:0, zero-extended, to the offset in bits 25:16. It takes no payload.
- R8: Opcode 0x5 pulses `restart_pulse`, with `restart_addr` equal to bits 27:0 shifted left by 4.
- R9: Opcode 0x6 takes exactly one payload word and does not write a register. That word raises `gather_pulse` with `gather_addr` set to the word. It also carries the header's offset (bits 25:16), count (bits 13:0) and insert flag (bit 15).
- R10: Opcode 0xE reads a sub-op from bits 27:24. Sub-op 0 pulses `lock_acquire` and sub-op 1 pulses `lock_release`, each with `lock_index` set to bits 7:0. Any other sub-op pulses `decode_err`, and decoding continues with the next word.
- R11: Opcode 0xF pulses `done_pulse`. Opcodes 0x7 to 0xD are headers that produce nothing.
- R12: A header whose payload count is zero leaves the decoder expecting a header. A word inside a payload is never decoded as a header, whatever its top bits hold.
- R13: All outputs appear one cycle after the word is accepted. Pulses last one cycle, and at most one pulse or write is active at a time. Nothing is emitted in a cycle after no word was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command word present |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted when valid (always high) |
| wr_valid | output | 1 | Register write strobe |
| wr_class | output | 10 | Class of the write |
| wr_offset | output | 12 | Register offset of the write |
| wr_data | output | 32 | Write data |
| restart_pulse | output | 1 | Restart request |
| restart_addr | output | 32 | Restart target address |
| gather_pulse | output | 1 | Gather request |
| gather_offset | output | 12 | Gather register offset |
| gather_count | output | 14 | Gather word count |
| gather_insert | output | 1 | Gather insert flag |
| gather_addr | output | 32 | Gather address word |
| lock_acquire | output | 1 | Lock acquire request |
| lock_release | output | 1 | Lock release request |
| lock_index | output | 8 | Lock index for acquire or release |
| done_pulse | output | 1 | Stream done |
| decode_err | output | 1 | Unknown extended sub-op |

## Verification
A header/payload state that goes wrong shows on the very next accepted word. If payload is taken as a header, the write stream stops and stray events appear. If a header is taken as payload, a write appears with that header as its data. A wrong remaining count is seen only when the block is due to return to header mode, so the bench follows each block with a header whose result is easy to recognise. A bad offset or mask register shows on `wr_offset` one cycle after the payload word that used it. A stale class register shows on the first write after a class change.

// File: rtl/cmdstream_pkg.sv
// Shared constants, types and helpers for the command stream decoder.
// Assumes the fixed 32-bit header layout; widths here follow that layout.
package cmdstream_pkg;

    localparam int CMD_W   = 32;
    localparam int OP_W    = 4;
    localparam int CLASS_W = 10;
    localparam int OFF_W   = 12;
    localparam int CNT_W   = 16;
    localparam int MASK_W  = 16;
    localparam int GCNT_W  = 14;
    localparam int LOCK_W  = 8;
    localparam int IMM_W   = 16;
    localparam int SUB_W   = 4;
    localparam int IDX_W   = $clog2(MASK_W);

    localparam logic [OP_W-1:0] OPC_SETCLASS = 4'h0;
    localparam logic [OP_W-1:0] OPC_INCR     = 4'h1;
    localparam logic [OP_W-1:0] OPC_FIXED    = 4'h2;
    localparam logic [OP_W-1:0] OPC_MASKED   = 4'h3;
    localparam logic [OP_W-1:0] OPC_IMM      = 4'h4;
    localparam logic [OP_W-1:0] OPC_RESTART  = 4'h5;
    localparam logic [OP_W-1:0] OPC_GATHER   = 4'h6;
    localparam logic [OP_W-1:0] OPC_EXT      = 4'hE;
    localparam logic [OP_W-1:0] OPC_DONE     = 4'hF;

    localparam logic [SUB_W-1:0] SUB_ACQ = 4'h0;
    localparam logic [SUB_W-1:0] SUB_REL = 4'h1;

    typedef enum logic {ST_HDR, ST_PAY} dec_state_e;

    typedef enum logic [1:0] {PM_INCR, PM_FIXED, PM_MASK, PM_GATHER} pay_mode_e;

    typedef struct packed {
        logic                 set_class;
        logic [CLASS_W-1:0]   cls;
        logic                 opens;
        pay_mode_e            mode;
        logic [OFF_W-1:0]     offset;
        logic [CNT_W-1:0]     count;
        logic [MASK_W-1:0]    mask;
        logic                 imm;
        logic [IMM_W-1:0]     imm_data;
        logic                 restart;
        logic [CMD_W-1:0]     restart_addr;
        logic [GCNT_W-1:0]    gcount;
        logic                 ginsert;
        logic                 acq;
        logic                 rel;
        logic                 err;
        logic                 done;
        logic [LOCK_W-1:0]    lock_idx;
    } hdr_info_t;

    // Number of set bits in a mask-sized vector.
    function automatic logic [CNT_W-1:0] bit_count(input logic [MASK_W-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int k = 0; k < MASK_W; k++) begin
            n = n + CNT_W'(v[k]);
        end
        return n;
    endfunction

endpackage

// File: rtl/cmd_header_decode.sv
// Combinational header decoder: splits one header word into the fields and
// intent flags the sequencer needs. Assumes the word is known to be a header.
module cmd_header_decode
    import cmdstream_pkg::*;
(
    input  logic [CMD_W-1:0] word,
    output hdr_info_t        info
);

    logic [OP_W-1:0]  opc;
    logic [SUB_W-1:0] sub;
    logic [OFF_W-1:0] short_off;
    logic [MASK_W-1:0] small_mask;

    assign opc        = word[31:28];
    assign sub        = word[27:24];
    assign short_off  = OFF_W'(word[25:16]);
    assign small_mask = MASK_W'(word[5:0]);

    // Field extraction and payload sizing per opcode.
    always_comb begin
        info = '0;
        case (opc)
            OPC_SETCLASS: begin
                info.set_class = 1'b1;
                info.cls       = word[15:6];
                info.offset    = word[27:16];
                info.mask      = small_mask;
                info.count     = bit_count(small_mask);
                info.mode      = PM_MASK;
                info.opens     = |word[5:0];
            end
            OPC_INCR: begin
                info.offset = short_off;
                info.count  = word[15:0];
                info.mode   = PM_INCR;
                info.opens  = |word[15:0];
            end
            OPC_FIXED: begin
                info.offset = short_off;
                info.count  = word[15:0];
                info.mode   = PM_FIXED;
                info.opens  = |word[15:0];
            end
            OPC_MASKED: begin
                info.offset = short_off;
                info.mask   = word[15:0];
                info.count  = bit_count(word[15:0]);
                info.mode   = PM_MASK;
                info.opens  = |word[15:0];
            end
            OPC_IMM: begin
                info.imm      = 1'b1;
                info.offset   = short_off;
                info.imm_data = word[15:0];
            end
            OPC_RESTART: begin
                info.restart      = 1'b1;
                info.restart_addr = {word[27:0], 4'b0000};
            end
            OPC_GATHER: begin
                info.opens   = 1'b1;
                info.count   = CNT_W'(1);
                info.mode    = PM_GATHER;
                info.offset  = short_off;
                info.gcount  = word[13:0];
                info.ginsert = word[15];
            end
            OPC_EXT: begin
                info.lock_idx = word[7:0];
                info.acq      = (sub == SUB_ACQ);
                info.rel      = (sub == SUB_REL);
                info.err      = (sub != SUB_ACQ) && (sub != SUB_REL);
            end
            OPC_DONE: begin
                info.done = 1'b1;
            end
            default: begin
                info = '0;
            end
        endcase
    end

endmodule

// File: rtl/cmd_lowbit.sv
// Lowest-set-bit finder for the masked addressing walk: gives the index of
// the lowest set bit and the mask with that bit cleared. Assumes W >= 2.
module cmd_lowbit #(
    parameter int W   = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  rest
);

    logic [W-1:0] below;
    logic [W-1:0] sel;

    // One-hot select of the lowest set bit, built as a ripple of "any lower bit set".
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_first
            assign below[i] = 1'b0;
        end else begin : g_next
            assign below[i] = below[i-1] | mask[i-1];
        end
        assign sel[i] = mask[i] & ~below[i];
    end

    // Encode the one-hot select to a binary index.
    always_comb begin
        idx = '0;
        for (int k = 0; k < W; k++) begin
            if (sel[k]) idx = idx | IW'(k);
        end
    end

    assign rest = mask & ~sel;

endmodule

// File: rtl/cmdstream_decoder.sv
// Command stream decoder top. Tracks header/payload state, the remaining
// payload count, the current class and the per-opcode addressing state, and
// emits registered writes and event pulses one cycle after each accepted word.
// Assumes downstream consumers always take the outputs (no backpressure).
module cmdstream_decoder
    import cmdstream_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [31:0]        in_data,
    output logic               in_ready,
    output logic               wr_valid,
    output logic [9:0]         wr_class,
    output logic [11:0]        wr_offset,
    output logic [31:0]        wr_data,
    output logic               restart_pulse,
    output logic [31:0]        restart_addr,
    output logic               gather_pulse,
    output logic [11:0]        gather_offset,
    output logic [13:0]        gather_count,
    output logic               gather_insert,
    output logic [31:0]        gather_addr,
    output logic               lock_acquire,
    output logic               lock_release,
    output logic [7:0]         lock_index,
    output logic               done_pulse,
    output logic               decode_err
);

    dec_state_e         state_q;
    pay_mode_e          mode_q;
    logic [CNT_W-1:0]   remain_q;
    logic [OFF_W-1:0]   off_q;
    logic [MASK_W-1:0]  mask_q;
    logic [CLASS_W-1:0] class_q;
    logic [GCNT_W-1:0]  gcnt_q;
    logic               gins_q;

    logic               wr_valid_q;
    logic [CLASS_W-1:0] wr_class_q;
    logic [OFF_W-1:0]   wr_off_q;
    logic [CMD_W-1:0]   wr_data_q;
    logic               rs_q;
    logic [CMD_W-1:0]   rs_addr_q;
    logic               ga_q;
    logic [OFF_W-1:0]   ga_off_q;
    logic [GCNT_W-1:0]  ga_cnt_q;
    logic               ga_ins_q;
    logic [CMD_W-1:0]   ga_addr_q;
    logic               acq_q;
    logic               rel_q;
    logic [LOCK_W-1:0]  lock_q;
    logic               done_q;
    logic               err_q;

    hdr_info_t          hinfo;
    logic [IDX_W-1:0]   low_idx;
    logic [MASK_W-1:0]  mask_rest;
    logic               accept;

    cmd_header_decode u_hdr (
        .word (in_data),
        .info (hinfo)
    );

    cmd_lowbit #(.W(MASK_W)) u_low (
        .mask (mask_q),
        .idx  (low_idx),
        .rest (mask_rest)
    );

    assign in_ready = 1'b1;
    assign accept   = in_valid & in_ready;

    // Sequencer: header decode, payload walk and registered output update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_HDR;
            mode_q     <= PM_INCR;
            remain_q   <= '0;
            off_q      <= '0;
            mask_q     <= '0;
            class_q    <= '0;
            gcnt_q     <= '0;
            gins_q     <= 1'b0;
            wr_valid_q <= 1'b0;
            wr_class_q <= '0;
            wr_off_q   <= '0;
            wr_data_q  <= '0;
            rs_q       <= 1'b0;
            rs_addr_q  <= '0;
            ga_q       <= 1'b0;
            ga_off_q   <= '0;
            ga_cnt_q   <= '0;
            ga_ins_q   <= 1'b0;
            ga_addr_q  <= '0;
            acq_q      <= 1'b0;
            rel_q      <= 1'b0;
            lock_q     <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            wr_valid_q <= 1'b0;
            rs_q       <= 1'b0;
            ga_q       <= 1'b0;
            acq_q      <= 1'b0;
            rel_q      <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            if (accept) begin
                if (state_q == ST_HDR) begin
                    if (hinfo.set_class) class_q <= hinfo.cls;
                    if (hinfo.imm) begin
                        wr_valid_q <= 1'b1;
                        wr_class_q <= class_q;
                        wr_off_q   <= hinfo.offset;
                        wr_data_q  <= CMD_W'(hinfo.imm_data);
                    end
                    if (hinfo.restart) begin
                        rs_q      <= 1'b1;
                        rs_addr_q <= hinfo.restart_addr;
                    end
                    if (hinfo.acq || hinfo.rel) lock_q <= hinfo.lock_idx;
                    acq_q  <= hinfo.acq;
                    rel_q  <= hinfo.rel;
                    err_q  <= hinfo.err;
                    done_q <= hinfo.done;
                    if (hinfo.opens) begin
                        state_q  <= ST_PAY;
                        mode_q   <= hinfo.mode;
                        remain_q <= hinfo.count;
                        off_q    <= hinfo.offset;
                        mask_q   <= hinfo.mask;
                        gcnt_q   <= hinfo.gcount;
                        gins_q   <= hinfo.ginsert;
                    end
                end else begin
                    case (mode_q)
                        PM_INCR: begin
                            wr_valid_q <= 1'b1;
                            wr_class_q <= class_q;
                            wr_off_q   <= off_q;
                            wr_data_q  <= in_data;
                            off_q      <= off_q + OFF_W'(1);
                        end
                        PM_FIXED: begin
                            wr_valid_q <= 1'b1;
                            wr_class_q <= class_q;
                            wr_off_q   <= off_q;
                            wr_data_q  <= in_data;
                        end
                        PM_MASK: begin
                            wr_valid_q <= 1'b1;
                            wr_class_q <= class_q;
                            wr_off_q   <= off_q + OFF_W'(low_idx);
                            wr_data_q  <= in_data;
                            mask_q     <= mask_rest;
                        end
                        default: begin
                            ga_q      <= 1'b1;
                            ga_off_q  <= off_q;
                            ga_cnt_q  <= gcnt_q;
                            ga_ins_q  <= gins_q;
                            ga_addr_q <= in_data;
                        end
                    endcase
                    remain_q <= remain_q - CNT_W'(1);
                    if (remain_q == CNT_W'(1)) state_q <= ST_HDR;
                end
            end
        end
    end

    assign wr_valid      = wr_valid_q;
    assign wr_class      = wr_class_q;
    assign wr_offset     = wr_off_q;
    assign wr_data       = wr_data_q;
    assign restart_pulse = rs_q;
    assign restart_addr  = rs_addr_q;
    assign gather_pulse  = ga_q;
    assign gather_offset = ga_off_q;
    assign gather_count  = ga_cnt_q;
    assign gather_insert = ga_ins_q;
    assign gather_addr   = ga_addr_q;
    assign lock_acquire  = acq_q;
    assign lock_release  = rel_q;
    assign lock_index    = lock_q;
    assign done_pulse    = done_q;
    assign decode_err    = err_q;

endmodule

// File: rtl/cmdstream_decoder_chk.sv
// Property checker for the command stream decoder, attached by bind.
// Observes ports plus the internal class register.
module cmdstream_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] in_data,
    input logic        wr_valid,
    input logic        restart_pulse,
    input logic [31:0] restart_addr,
    input logic        gather_pulse,
    input logic        lock_acquire,
    input logic        lock_release,
    input logic        done_pulse,
    input logic        decode_err,
    input logic [9:0]  class_q
);

    logic [6:0] outs;
    assign outs = {wr_valid, restart_pulse, gather_pulse, lock_acquire,
                   lock_release, done_pulse, decode_err};

    // At most one write or event per cycle (R13).
    assert_one_event_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(outs));

    // No output without an accepted word on the previous edge (R13).
    assert_quiet_when_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> (outs == 7'b0));

    // Restart addresses are 16-byte aligned (R8).
    assert_restart_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |-> (restart_addr[3:0] == 4'b0000));

    // Class only changes on a word whose top nibble is the class opcode (R3).
    assert_class_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_data[31:28] == 4'h0) |=> $stable(class_q));

    // The block always accepts (R1).
    assert_always_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> in_ready);

endmodule

bind cmdstream_decoder cmdstream_decoder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_data       (in_data),
    .wr_valid      (wr_valid),
    .restart_pulse (restart_pulse),
    .restart_addr  (restart_addr),
    .gather_pulse  (gather_pulse),
    .lock_acquire  (lock_acquire),
    .lock_release  (lock_release),
    .done_pulse    (done_pulse),
    .decode_err    (decode_err),
    .class_q       (class_q)
);

// File: tb/cmdstream_decoder_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model driven word by word, compared every clock.
module cmdstream_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        wr_valid;
    logic [9:0]  wr_class;
    logic [11:0] wr_offset;
    logic [31:0] wr_data;
    logic        restart_pulse;
    logic [31:0] restart_addr;
    logic        gather_pulse;
    logic [11:0] gather_offset;
    logic [13:0] gather_count;
    logic        gather_insert;
    logic [31:0] gather_addr;
    logic        lock_acquire;
    logic        lock_release;
    logic [7:0]  lock_index;
    logic        done_pulse;
    logic        decode_err;

    always #2.5 clk = ~clk;

    cmdstream_decoder u_dut (.*);

    int checks = 0;
    int errors = 0;

    // Reference model state
    int          m_pay = 0;
    int          m_mode = 0;   // 1 incr, 2 fixed, 3 mask, 6 gather
    int          m_cnt = 0;
    int          m_off = 0;
    logic [15:0] m_mask = '0;
    int          m_cls = 0;
    int          m_gcnt = 0;
    int          m_gins = 0;
    string       tag_ovr = "";

    // Expected outputs for the coming cycle
    bit    e_wr, e_rs, e_ga, e_acq, e_rel, e_done, e_err;
    int    e_cls, e_off, e_goff, e_gcnt, e_gins, e_lock;
    logic [31:0] e_data, e_rsaddr, e_gaddr;
    string e_tag;

    task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    function automatic void model_step(input bit v, input logic [31:0] w);
        int op, sub, idx;
        e_wr = 0; e_rs = 0; e_ga = 0; e_acq = 0; e_rel = 0; e_done = 0; e_err = 0;
        e_tag = "R13";
        if (!v) return;
        if (m_pay == 0) begin
            op = int'(w[31:28]);
            case (op)
                0: begin
                    e_tag = "R2"; m_cls = int'(w[15:6]); m_off = int'(w[27:16]);
                    m_mask = {10'b0, w[5:0]}; m_cnt = $countones(w[5:0]); m_mode = 3;
                end
                1, 2: begin
                    e_tag = (op == 1) ? "R4" : "R5"; m_off = int'(w[25:16]);
                    m_cnt = int'(w[15:0]); m_mode = op;
                end
                3: begin
                    e_tag = "R6"; m_off = int'(w[25:16]); m_mask = w[15:0];
                    m_cnt = $countones(w[15:0]); m_mode = 3;
                end
                4: begin
                    e_tag = "R7"; e_wr = 1; e_cls = m_cls; e_off = int'(w[25:16]);
                    e_data = {16'h0, w[15:0]};
                end
                5: begin
                    e_tag = "R8"; e_rs = 1; e_rsaddr = w << 4;
                end
                6: begin
                    e_tag = "R9"; m_off = int'(w[25:16]); m_gcnt = int'(w[13:0]);
                    m_gins = int'(w[15]); m_cnt = 1; m_mode = 6;
                end
                14: begin
                    e_tag = "R10"; sub = int'(w[27:24]); e_lock = int'(w[7:0]);
                    if (sub == 0) e_acq = 1;
                    else if (sub == 1) e_rel = 1;
                    else e_err = 1;
                end
                15: begin
                    e_tag = "R11"; e_done = 1;
                end
                default: e_tag = "R11";
            endcase
            if (op <= 3 || op == 6) m_pay = (m_cnt != 0) ? 1 : 0;
        end else begin
            case (m_mode)
                1: begin e_tag = "R4"; e_wr = 1; e_off = m_off % 4096; m_off = m_off + 1; end
                2: begin e_tag = "R5"; e_wr = 1; e_off = m_off % 4096; end
                3: begin
                    e_tag = "R6"; idx = 0;
                    for (int k = 15; k >= 0; k--) if (m_mask[k]) idx = k;
                    m_mask[idx] = 1'b0;
                    e_wr = 1; e_off = (m_off + idx) % 4096;
                end
                default: begin
                    e_tag = "R9"; e_ga = 1; e_goff = m_off; e_gcnt = m_gcnt;
                    e_gins = m_gins; e_gaddr = w;
                end
            endcase
            if (e_wr) begin e_cls = m_cls; e_data = w; end
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) m_pay = 0;
        end
        if (tag_ovr != "") e_tag = tag_ovr;
    endfunction

    task automatic compare();
        chk(in_ready === 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
        chk(wr_valid === e_wr, {e_tag, " wr_valid"}, 64'(wr_valid), 64'(e_wr));
        if (e_wr && wr_valid) begin
            chk(wr_class === 10'(e_cls), "R3 wr_class", 64'(wr_class), 64'(e_cls));
            chk(wr_offset === 12'(e_off), {e_tag, " wr_offset"}, 64'(wr_offset), 64'(e_off));
            chk(wr_data === e_data, {e_tag, " wr_data"}, 64'(wr_data), 64'(e_data));
        end
        chk(restart_pulse === e_rs, {e_tag, " restart"}, 64'(restart_pulse), 64'(e_rs));
        if (e_rs) chk(restart_addr === e_rsaddr, "R8 restart_addr", 64'(restart_addr), 64'(e_rsaddr));
        chk(gather_pulse === e_ga, {e_tag, " gather"}, 64'(gather_pulse), 64'(e_ga));
        if (e_ga) begin
            chk(gather_offset === 12'(e_goff), "R9 gather_offset", 64'(gather_offset), 64'(e_goff));
            chk(gather_count === 14'(e_gcnt), "R9 gather_count", 64'(gather_count), 64'(e_gcnt));
            chk(gather_insert === 1'(e_gins), "R9 gather_insert", 64'(gather_insert), 64'(e_gins));
            chk(gather_addr === e_gaddr, "R9 gather_addr", 64'(gather_addr), 64'(e_gaddr));
        end
        chk(lock_acquire === e_acq, {e_tag, " lock_acquire"}, 64'(lock_acquire), 64'(e_acq));
        chk(lock_release === e_rel, {e_tag, " lock_release"}, 64'(lock_release), 64'(e_rel));
        if (e_acq || e_rel) chk(lock_index === 8'(e_lock), "R10 lock_index", 64'(lock_index), 64'(e_lock));
        chk(decode_err === e_err, {e_tag, " decode_err"}, 64'(decode_err), 64'(e_err));
        chk(done_pulse === e_done, {e_tag, " done"}, 64'(done_pulse), 64'(e_done));
    endtask

    // One clock: drive at the falling edge, model the accept, compare after the rising edge.
    task automatic cyc(input bit v, input logic [31:0] w);
        in_valid = v;
        in_data  = w;
        model_step(v, w);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic put(input logic [31:0] w);
        cyc(1'b1, w);
    endtask

    task automatic idle();
        cyc(1'b0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        e_tag = "R1";
        e_wr = 0; e_rs = 0; e_ga = 0; e_acq = 0; e_rel = 0; e_done = 0; e_err = 0;
        compare();
        rst_n = 1'b1;
        idle();
        // R1/R3: class is zero after reset, seen on an immediate write
        put(32'h4_123_BEEF);
        // R2/R3: class set, offset 0x010, mask 100101 -> offsets 0x10, 0x12, 0x15
        put({4'h0, 12'h010, 10'h155, 6'b100101});
        put(32'hAAAA0001);
        idle();
        put(32'hAAAA0002);
        put(32'hF0000000); // R12: header-like word inside payload is data
        // R4: incrementing write, offset 0x3FF, 2 words (wraps past 10 bits)
        put(32'h13FF_0002);
        put(32'h11111111);
        put(32'h22222222);
        // R4: offset 0x020, 3 words
        put(32'h1020_0003);
        put(32'h5);
        put(32'h6);
        put(32'h7);
        // R12: zero-count headers fall straight back to header mode
        tag_ovr = "R12";
        put(32'h1040_0000);
        put(32'h2040_0000);
        put(32'h3040_0000);
        put({4'h0, 12'h0, 10'h2A5, 6'b0});
        put(32'h4_050_1234);
        tag_ovr = "";
        // R5: fixed offset 0x3FF, 2 words
        put(32'h23FF_0002);
        put(32'hCAFEF00D);
        idle();
        put(32'h0BADC0DE);
        // R6: masked, offset 0x100, mask 0x8001 -> 0x100, 0x10F
        put(32'h3100_8001);
        put(32'h12345678);
        put(32'h9ABCDEF0);
        // R6: masked with dense mask 0x00F0
        put(32'h3200_00F0);
        for (int k = 0; k < 4; k++) put(32'h100 + 32'(k));
        // R8: restart
        put(32'h5ABCDEF1);
        // R9: gather with insert and max count, then address word
        put(32'h6123_BFFF);
        put(32'hDEADBEEF);
        put(32'h6045_0010);
        idle();
        put(32'h00001000);
        // R10: lock requests and unknown sub-op
        put(32'hE00000AB);
        put(32'hE1000007);
        put(32'hE7000001);
        put(32'h4_001_0042);
        // R11: opcodes with no effect, then done
        for (int k = 7; k <= 13; k++) put({4'(k), 28'hFFFFFFF});
        put(32'h4_002_0099);
        put(32'hF0000000);
        // R3: new class applies to the class header's own payload and after
        put({4'h0, 12'h300, 10'h3FF, 6'b000001});
        put(32'h77777777);
        put(32'h4_003_0001);
        idle();
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule